// File: doc/BRIEF.md
# Auxiliary Channel Request Framer and Reply Parser

This block sits between a transaction sequencer and the serialiser of a display auxiliary channel. On the transmit side it takes one request: a 4-bit command, a 20-bit address, a byte length and, for write commands, a stream of payload bytes. It turns the request into the byte sequence the link expects and hands it out one byte at a time over a valid/ready stream. The stream marks its final byte and gives the total byte count for the frame.

On the receive side a reply is announced by a start pulse. The pulse carries the number of received bytes, the size of the caller's buffer and a flag that says the sink was unplugged. The received bytes then arrive one per valid cycle. The parser pulls the status code out of the first byte. When the status is an acknowledge and the bytes fit the buffer, it forwards the rest as payload. In every case it ends the reply with a one-cycle done pulse that carries the status, the payload length and one of three error flags.

Encoding and decoding of the physical line, sync patterns and the PHY are handled elsewhere.

Top module: `aux_frame_codec`

## Requirements
- R1: The first three transmitted bytes are: {command, address[19:16]} with the command in bits 7:4; then address[15:8]; then address[7:0].
- R2: When the requested length is nonzero, a fourth header byte equal to length minus one follows the address. When the length is zero the header is three bytes long.
- R3: Only commands 4'h8 (native write), 4'h0 (I2C write) and 4'h4 (I2C write, middle of transaction) are writes. For a write, length payload bytes taken from the write-data stream follow the header. For any other command no payload is sent. tx_count equals header size plus the payload byte count.
- R4: Bytes leave only on a tx_valid/tx_ready handshake, and tx_last is high on the final byte. req_ready is high only when no frame is in progress, and tx_valid stays low at that time.
- R5: The reply status is bits 7:4 of the first received byte, and status 0 means acknowledge.
- R6: A reply announced with a received count of zero ends with err_empty set, status 0 and length 0.
- R7: For an acknowledge where received count minus one exceeds rx_limit, the reply ends with err_over set and length 0, and no payload byte is forwarded.
- R8: A start pulse with rx_disc set ends the reply on the next cycle with err_disc set, status 0 and length 0.
- R9: For a nonzero status, the parser reports that status with length 0 and forwards no payload byte.
- R10: For an acknowledge that fits the buffer, received bytes 1 onward appear in order on pay_valid/pay_data, and rsp_len equals received count minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Framer idle, request taken |
| req_cmd | input | 4 | Command code |
| req_addr | input | 20 | Target address |
| req_len | input | LEN_W | Requested byte count, 0..MAX_LEN |
| wr_valid | input | 1 | Write payload byte present |
| wr_ready | output | 1 | Write payload byte taken |
| wr_data | input | 8 | Write payload byte |
| tx_valid | output | 1 | Frame byte present |
| tx_ready | input | 1 | Frame byte taken |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of frame |
| tx_count | output | TOT_W | Total bytes in current frame |
| rx_start | input | 1 | Reply announcement pulse |
| rx_count | input | CNT_W | Number of received reply bytes |
| rx_limit | input | LEN_W | Caller buffer size in bytes |
| rx_disc | input | 1 | Sink disconnected |
| rx_valid | input | 1 | Reply byte present |
| rx_data | input | 8 | Reply byte |
| pay_valid | output | 1 | Payload byte forwarded |
| pay_data | output | 8 | Payload byte |
| rsp_done | output | 1 | Reply finished (one cycle) |
| rsp_status | output | 4 | Reply status code |
| rsp_len | output | CNT_W | Payload byte count |
| err_empty | output | 1 | Reply had no bytes |
| err_over | output | 1 | Payload larger than buffer |
| err_disc | output | 1 | Reply aborted by disconnect |

## Verification
The checks assume that rx_start is only pulsed while no reply is being parsed, that exactly rx_count bytes follow it (none when rx_disc is set), and that req_len never exceeds MAX_LEN. The bench gives the framer one request at a time and waits until the expected byte queue has drained before the next. It issues each reply only after the previous done pulse and sends exactly the announced byte count. Gaps are placed at random in the write-data, ready and reply streams, so pass-through stalls are exercised without breaking those rules.

// File: rtl/aux_frame_codec.sv
module aux_frame_codec #(
  parameter int MAX_LEN = 16,
  localparam int LEN_W = $clog2(MAX_LEN + 1),
  localparam int TOT_W = $clog2(MAX_LEN + 5),
  localparam int CNT_W = $clog2(MAX_LEN + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [3:0]       req_cmd,
  input  logic [19:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  output logic [TOT_W-1:0] tx_count,
  input  logic             rx_start,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [LEN_W-1:0] rx_limit,
  input  logic             rx_disc,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  output logic             pay_valid,
  output logic [7:0]       pay_data,
  output logic             rsp_done,
  output logic [3:0]       rsp_status,
  output logic [CNT_W-1:0] rsp_len,
  output logic             err_empty,
  output logic             err_over,
  output logic             err_disc
);

  localparam logic [3:0] CMD_NWR     = 4'h8;
  localparam logic [3:0] CMD_IWR     = 4'h0;
  localparam logic [3:0] CMD_IWR_MOT = 4'h4;

  // ---------------- request framer ----------------
  logic             busy;
  logic [3:0]       cmd_q;
  logic [19:0]      addr_q;
  logic [LEN_W-1:0] len_q;
  logic [TOT_W-1:0] hdr_q, total_q, idx_q;

  logic             is_wr;
  logic [TOT_W-1:0] hdr_n;
  logic             in_hdr;
  logic [7:0]       len_m1;

  assign is_wr  = (req_cmd == CMD_NWR) || (req_cmd == CMD_IWR) || (req_cmd == CMD_IWR_MOT);
  assign hdr_n  = (req_len != '0) ? TOT_W'(4) : TOT_W'(3);
  assign in_hdr = idx_q < hdr_q;
  assign len_m1 = 8'(len_q) - 8'd1;

  assign req_ready = !busy;
  assign tx_valid  = busy && (in_hdr || wr_valid);
  assign wr_ready  = busy && !in_hdr && tx_ready;
  assign tx_last   = busy && (idx_q == total_q - TOT_W'(1));
  assign tx_count  = total_q;

  always_comb begin
    tx_data = wr_data;
    if (in_hdr) begin
      case (idx_q)
        TOT_W'(0): tx_data = {cmd_q, addr_q[19:16]};
        TOT_W'(1): tx_data = addr_q[15:8];
        TOT_W'(2): tx_data = addr_q[7:0];
        default:   tx_data = len_m1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cmd_q   <= '0;
      addr_q  <= '0;
      len_q   <= '0;
      hdr_q   <= '0;
      total_q <= '0;
      idx_q   <= '0;
    end else if (!busy) begin
      if (req_valid) begin
        busy    <= 1'b1;
        cmd_q   <= req_cmd;
        addr_q  <= req_addr;
        len_q   <= req_len;
        hdr_q   <= hdr_n;
        total_q <= hdr_n + (is_wr ? TOT_W'(req_len) : TOT_W'(0));
        idx_q   <= '0;
      end
    end else if (tx_valid && tx_ready) begin
      idx_q <= idx_q + TOT_W'(1);
      if (tx_last) busy <= 1'b0;
    end
  end

  // ---------------- reply parser ----------------
  typedef enum logic [1:0] {P_IDLE, P_STAT, P_PAY, P_DRAIN} pstate_t;
  pstate_t          pst;
  logic [CNT_W-1:0] left_q, cnt_q;
  logic [LEN_W-1:0] limit_q;
  logic [3:0]       stat_q;
  logic             over_q;
  logic [3:0]       stat_in;
  logic             fits;

  assign stat_in   = rx_data[7:4];
  assign fits      = (cnt_q - CNT_W'(1)) <= CNT_W'(limit_q);
  assign pay_valid = (pst == P_PAY) && rx_valid;
  assign pay_data  = rx_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pst        <= P_IDLE;
      left_q     <= '0;
      cnt_q      <= '0;
      limit_q    <= '0;
      stat_q     <= '0;
      over_q     <= 1'b0;
      rsp_done   <= 1'b0;
      rsp_status <= '0;
      rsp_len    <= '0;
      err_empty  <= 1'b0;
      err_over   <= 1'b0;
      err_disc   <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      case (pst)
        P_IDLE: if (rx_start) begin
          if (rx_disc || rx_count == '0) begin
            rsp_done   <= 1'b1;
            rsp_status <= '0;
            rsp_len    <= '0;
            err_disc   <= rx_disc;
            err_empty  <= !rx_disc;
            err_over   <= 1'b0;
          end else begin
            cnt_q   <= rx_count;
            left_q  <= rx_count;
            limit_q <= rx_limit;
            pst     <= P_STAT;
          end
        end
        P_STAT: if (rx_valid) begin
          left_q <= left_q - CNT_W'(1);
          stat_q <= stat_in;
          over_q <= (stat_in == 4'd0) && !fits;
          if (left_q == CNT_W'(1)) begin
            rsp_done   <= 1'b1;
            rsp_status <= stat_in;
            rsp_len    <= '0;
            err_disc   <= 1'b0;
            err_empty  <= 1'b0;
            err_over   <= 1'b0;
            pst        <= P_IDLE;
          end else if (stat_in == 4'd0 && fits) begin
            pst <= P_PAY;
          end else begin
            pst <= P_DRAIN;
          end
        end
        default: if (rx_valid) begin
          left_q <= left_q - CNT_W'(1);
          if (left_q == CNT_W'(1)) begin
            rsp_done   <= 1'b1;
            rsp_status <= stat_q;
            rsp_len    <= (pst == P_PAY) ? cnt_q - CNT_W'(1) : '0;
            err_disc   <= 1'b0;
            err_empty  <= 1'b0;
            err_over   <= over_q;
            pst        <= P_IDLE;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/aux_frame_codec_chk.sv
module aux_frame_codec_chk #(
  parameter int MAX_LEN = 16,
  localparam int TOT_W = $clog2(MAX_LEN + 5),
  localparam int CNT_W = $clog2(MAX_LEN + 2)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             tx_last,
  input logic [TOT_W-1:0] tx_count,
  input logic             rx_start,
  input logic             rx_disc,
  input logic             rx_valid,
  input logic             pay_valid,
  input logic             rsp_done,
  input logic [3:0]       rsp_status,
  input logic [CNT_W-1:0] rsp_len,
  input logic             err_empty,
  input logic             err_over,
  input logic             err_disc
);

  logic [TOT_W-1:0] beats;
  always_ff @(posedge clk) begin
    if (!rst_n) beats <= '0;
    else if (tx_valid && tx_ready) beats <= tx_last ? '0 : beats + TOT_W'(1);
  end

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !tx_valid);
  p_end_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last) |=> req_ready);
  p_count_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last) |-> (beats + TOT_W'(1) == tx_count));
  p_min_hdr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_count >= TOT_W'(3));
  p_err_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $countones({err_empty, err_over, err_disc}) <= 1);
  p_over_nolen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && err_over) |-> (rsp_len == '0 && rsp_status == 4'd0));
  p_disc_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_start && rx_disc) |=> (rsp_done && err_disc && rsp_len == '0));
  p_nack_nolen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_status != 4'd0) |-> (rsp_len == '0 && !err_over));
  p_pay_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid |-> rx_valid);

endmodule

bind aux_frame_codec aux_frame_codec_chk #(.MAX_LEN(MAX_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_last(tx_last), .tx_count(tx_count),
  .rx_start(rx_start), .rx_disc(rx_disc), .rx_valid(rx_valid),
  .pay_valid(pay_valid), .rsp_done(rsp_done), .rsp_status(rsp_status),
  .rsp_len(rsp_len), .err_empty(err_empty), .err_over(err_over),
  .err_disc(err_disc)
);

// File: tb/sim_aux_frame_codec.sv
module sim_aux_frame_codec;
  localparam int MAX_LEN = 16;
  localparam int LEN_W = $clog2(MAX_LEN + 1);
  localparam int TOT_W = $clog2(MAX_LEN + 5);
  localparam int CNT_W = $clog2(MAX_LEN + 2);

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic req_valid = 0, req_ready;
  logic [3:0] req_cmd = 0;
  logic [19:0] req_addr = 0;
  logic [LEN_W-1:0] req_len = 0;
  logic wr_valid = 0, wr_ready;
  logic [7:0] wr_data = 0;
  logic tx_valid, tx_ready = 0, tx_last;
  logic [7:0] tx_data;
  logic [TOT_W-1:0] tx_count;
  logic rx_start = 0, rx_disc = 0, rx_valid = 0;
  logic [CNT_W-1:0] rx_count = 0;
  logic [LEN_W-1:0] rx_limit = 0;
  logic [7:0] rx_data = 0;
  logic pay_valid, rsp_done, err_empty, err_over, err_disc;
  logic [7:0] pay_data;
  logic [3:0] rsp_status;
  logic [CNT_W-1:0] rsp_len;

  aux_frame_codec #(.MAX_LEN(MAX_LEN)) u0 (.*);

  int compared = 0, mismatched = 0;
  int exp_tx[$];
  string exp_tag[$];
  int wr_q[$];
  int cur_total = 0;
  bit wr_hs = 0;
  int exp_pay[$];
  bit rsp_pend = 0;
  int e_stat, e_len, e_empty, e_over, e_disc;
  string e_ltag;

  task automatic check(string tag, string what, int act, int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  // reference model comparison, every clock
  always @(negedge clk) begin
    wr_hs = wr_valid && wr_ready;
    if (rst_n) begin
      if (tx_valid && tx_ready) begin
        if (exp_tx.size() == 0) check("R4", "unexpected tx beat", 1, 0);
        else begin
          int b; string t;
          b = exp_tx.pop_front(); t = exp_tag.pop_front();
          check(t, "tx_data", int'(tx_data), b);
          check("R4", "tx_last", int'(tx_last), int'(exp_tx.size() == 0));
          check("R3", "tx_count", int'(tx_count), cur_total);
        end
      end else if (tx_valid && exp_tx.size() == 0) check("R4", "tx_valid while idle", 1, 0);
      if (pay_valid) begin
        if (exp_pay.size() == 0) check(e_ltag, "unexpected payload", 1, 0);
        else check("R10", "pay_data", int'(pay_data), exp_pay.pop_front());
      end
      if (rsp_done) begin
        if (!rsp_pend) check("R8", "unexpected done", 1, 0);
        else begin
          check("R5", "rsp_status", int'(rsp_status), e_stat);
          check(e_ltag, "rsp_len", int'(rsp_len), e_len);
          check("R6", "err_empty", int'(err_empty), e_empty);
          check("R7", "err_over", int'(err_over), e_over);
          check("R8", "err_disc", int'(err_disc), e_disc);
          check("R10", "payload left", exp_pay.size(), 0);
          rsp_pend = 0;
        end
      end
    end
  end

  // write-data feeder and random backpressure
  always @(posedge clk) begin
    #1;
    if (wr_hs && wr_q.size() > 0) void'(wr_q.pop_front());
    wr_valid = (wr_q.size() > 0) && ($urandom % 3 != 0);
    wr_data  = (wr_q.size() > 0) ? 8'(wr_q[0]) : 8'h00;
    tx_ready = ($urandom % 4 != 0);
  end

  task automatic send_req(logic [3:0] cmd, logic [19:0] addr, int len);
    bit w;
    int hdr;
    w = (cmd == 4'h8) || (cmd == 4'h0) || (cmd == 4'h4);
    hdr = (len != 0) ? 4 : 3;
    cur_total = hdr + (w ? len : 0);
    exp_tx.push_back({cmd, addr[19:16]}); exp_tag.push_back("R1");
    exp_tx.push_back(int'(addr[15:8]));   exp_tag.push_back("R1");
    exp_tx.push_back(int'(addr[7:0]));    exp_tag.push_back("R1");
    if (len != 0) begin exp_tx.push_back(len - 1); exp_tag.push_back("R2"); end
    if (w) for (int i = 0; i < len; i++) begin
      int d;
      d = (i * 37 + len + int'(addr[3:0])) & 255;
      exp_tx.push_back(d); exp_tag.push_back("R3");
      wr_q.push_back(d);
    end
    @(posedge clk); #1;
    req_valid = 1; req_cmd = cmd; req_addr = addr; req_len = LEN_W'(len);
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 0;
    while (exp_tx.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
    check("R3", "write bytes left", wr_q.size(), 0);
  endtask

  task automatic send_rsp(int cnt, int lim, bit disc, int b0);
    int st;
    e_stat = 0; e_len = 0; e_empty = 0; e_over = 0; e_disc = 0; e_ltag = "R9";
    st = (b0 >> 4) & 15;
    if (disc) e_disc = 1;
    else if (cnt == 0) e_empty = 1;
    else if (st != 0) e_stat = st;
    else if (cnt - 1 > lim) begin e_over = 1; e_ltag = "R7"; end
    else begin
      e_len = cnt - 1; e_ltag = "R10";
      for (int i = 1; i < cnt; i++) exp_pay.push_back((i * 29 + cnt) & 255);
    end
    rsp_pend = 1;
    @(posedge clk); #1;
    rx_start = 1; rx_count = CNT_W'(cnt); rx_limit = LEN_W'(lim); rx_disc = disc;
    @(posedge clk); #1;
    rx_start = 0; rx_disc = 0;
    if (!disc) for (int i = 0; i < cnt; i++) begin
      if ($urandom % 3 == 0) begin rx_valid = 0; @(posedge clk); #1; end
      rx_valid = 1;
      rx_data = (i == 0) ? 8'(b0) : 8'((i * 29 + cnt) & 255);
      @(posedge clk); #1;
    end
    rx_valid = 0;
    while (rsp_pend) @(posedge clk);
    exp_pay.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL R4 watchdog act=hung exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R4", "reset req_ready", int'(req_ready), 1);
    check("R4", "reset tx_valid", int'(tx_valid), 0);
    check("R8", "reset rsp_done", int'(rsp_done), 0);
    rst_n = 1;
    // reads: header only (R1, R2)
    send_req(4'h9, 20'hA1B2C, 0);
    send_req(4'h9, 20'h00F0F, MAX_LEN);
    send_req(4'h5, 20'hFFFFF, 1);
    send_req(4'h1, 20'h12345, 7);
    // writes (R3)
    send_req(4'h8, 20'h54321, 4);
    send_req(4'h0, 20'h0000A, 1);
    send_req(4'h4, 20'h9ABCD, MAX_LEN);
    send_req(4'h4, 20'h77777, 0);
    // replies
    send_rsp(4, 5, 0, 8'h0C);            // R10 ack, fits
    send_rsp(1, 0, 0, 8'h03);            // R5 ack status only
    send_rsp(MAX_LEN + 1, MAX_LEN, 0, 8'h00); // R10 full buffer
    send_rsp(3, 4, 0, 8'h1F);            // R9 nack
    send_rsp(2, 4, 0, 8'h25);            // R9 defer
    send_rsp(0, 4, 0, 0);                // R6 empty
    send_rsp(6, 3, 0, 8'h0E);            // R7 overflow
    send_rsp(3, 3, 1, 0);                // R8 disconnect
    send_rsp(4, 3, 0, 8'h01);            // R10 exact fit
    repeat (4) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule